// File: doc/BRIEF.md
# Static Dual-Issue Packet Decoder

This block sits between instruction fetch and the two execution lanes of a statically scheduled, two-wide 32-bit pipeline. Each fetched packet is 64 bits wide and holds two instruction words that the compiler has already paired. The lower word goes to the arithmetic/branch lane and the upper word goes to the load/store lane. The block registers both words, marks each one valid or idle, and tags each with a class bit that the lanes use for steering.

The compiler is trusted to avoid hazards, so the block never compares register fields and never stalls one slot against the other. It only checks the packet's form. It flags a word that sits in the wrong lane. It flags a packet whose address does not fall on an 8-byte boundary. In either case it withholds both slots. It also keeps the address of the next packet in sequence, which is the address of the last aligned packet plus eight. A stall input freezes every output.

Top module: `dual_issue_decoder`

## Requirements
- R1: One clock after an accepted packet (pkt_valid=1, stall=0), alu_insn shows packet bits [31:0] and mem_insn shows packet bits [63:32].
- R2: Each class flag equals bit 31 of its word. A value of 1 means load/store and 0 means ALU/branch.
- R3: An all-zero word is a nop. Its valid flag is 0, and it never causes a slot error.
- R4: slot_err is set when the low word is non-zero with bit 31 = 1, or when the high word is non-zero with bit 31 = 0. In that case both valid flags are 0. Otherwise a non-zero word is valid.
- R5: A packet whose address has bits [2:0] not equal to zero sets align_err, clears both valid flags, and leaves next_addr unchanged.
- R6: After an accepted packet with an aligned address, next_addr equals that address plus 8.
- R7: While stall is high, every output keeps its value and the packet inputs have no effect.
- R8: A cycle with pkt_valid=0 and stall=0 clears both words, both valid flags and both error flags, and keeps next_addr.
- R9: During reset every output is zero.
- R10: Both slots of a correct packet are valid in the same cycle, even when the upper word reads a register that the lower word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present this cycle |
| stall | input | 1 | Hold all outputs |
| pkt_addr | input | ADDR_W | Byte address of the packet |
| pkt_data | input | 2*INSN_W | Packet, low word first |
| alu_insn | output | INSN_W | ALU/branch slot word |
| alu_valid | output | 1 | ALU slot carries work |
| alu_class | output | 1 | Class bit of ALU slot word |
| mem_insn | output | INSN_W | Load/store slot word |
| mem_valid | output | 1 | Memory slot carries work |
| mem_class | output | 1 | Class bit of memory slot word |
| slot_err | output | 1 | Word in wrong slot |
| align_err | output | 1 | Packet address misaligned |
| next_addr | output | ADDR_W | Address of next packet in sequence |

## Verification
A fault in the slot-error or nop decode shows up on the valid flags in the cycle after the packet is accepted. This is why the bench sweeps every pair of opcode classes for the two words. A fault in the stall hold shows up as an output that changes during a stalled cycle, which is visible one clock later. A fault in the address register shows up as a wrong next_addr after a single aligned or misaligned packet.

// File: rtl/dual_issue_decoder.sv
module dual_issue_decoder #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  input  logic                  stall,
  input  logic [ADDR_W-1:0]     pkt_addr,
  input  logic [2*INSN_W-1:0]   pkt_data,
  output logic [INSN_W-1:0]     alu_insn,
  output logic                  alu_valid,
  output logic                  alu_class,
  output logic [INSN_W-1:0]     mem_insn,
  output logic                  mem_valid,
  output logic                  mem_class,
  output logic                  slot_err,
  output logic                  align_err,
  output logic [ADDR_W-1:0]     next_addr
);
  localparam int PKT_BYTES = (2*INSN_W)/8;
  localparam int OFF_W     = $clog2(PKT_BYTES);

  logic [INSN_W-1:0] w_lo, w_hi;
  logic lo_nop, hi_nop, lo_bad, hi_bad, misal, bad, take;

  assign w_lo   = pkt_data[INSN_W-1:0];
  assign w_hi   = pkt_data[2*INSN_W-1:INSN_W];
  assign lo_nop = (w_lo == '0);
  assign hi_nop = (w_hi == '0);
  assign lo_bad = !lo_nop &&  w_lo[INSN_W-1];
  assign hi_bad = !hi_nop && !w_hi[INSN_W-1];
  assign misal  = (pkt_addr[OFF_W-1:0] != '0);
  assign bad    = lo_bad || hi_bad || misal;
  assign take   = pkt_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_insn  <= '0;
      mem_insn  <= '0;
      alu_valid <= 1'b0;
      mem_valid <= 1'b0;
      slot_err  <= 1'b0;
      align_err <= 1'b0;
      next_addr <= '0;
    end else if (!stall) begin
      alu_insn  <= pkt_valid ? w_lo : '0;
      mem_insn  <= pkt_valid ? w_hi : '0;
      alu_valid <= pkt_valid && !lo_nop && !bad;
      mem_valid <= pkt_valid && !hi_nop && !bad;
      slot_err  <= pkt_valid && (lo_bad || hi_bad);
      align_err <= pkt_valid && misal;
      if (take && !misal)
        next_addr <= pkt_addr + ADDR_W'(PKT_BYTES);
    end
  end

  assign alu_class = alu_insn[INSN_W-1];
  assign mem_class = mem_insn[INSN_W-1];
endmodule

module dual_issue_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              stall,
  input logic [ADDR_W-1:0] pkt_addr,
  input logic [INSN_W-1:0] alu_insn,
  input logic              alu_valid,
  input logic              alu_class,
  input logic [INSN_W-1:0] mem_insn,
  input logic              mem_valid,
  input logic              mem_class,
  input logic              slot_err,
  input logic              align_err,
  input logic [ADDR_W-1:0] next_addr
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(alu_insn) && $stable(mem_insn) && $stable(alu_valid) &&
               $stable(mem_valid) && $stable(slot_err) && $stable(align_err) &&
               $stable(next_addr)));
  p_nop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid -> alu_insn != '0) && (mem_valid -> mem_insn != '0));
  p_err_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_err || align_err) |-> (!alu_valid && !mem_valid));
  p_lane_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid -> !alu_class) && (mem_valid -> mem_class));
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !pkt_valid) |=> (!alu_valid && !mem_valid && !slot_err && !align_err));
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && pkt_valid && pkt_addr[2:0] == 3'd0) |=> next_addr == $past(pkt_addr) + ADDR_W'(8));
  p_misal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && pkt_valid && pkt_addr[2:0] != 3'd0) |=> (align_err && $stable(next_addr)));
endmodule

bind dual_issue_decoder dual_issue_decoder_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .stall(stall), .pkt_addr(pkt_addr),
  .alu_insn(alu_insn), .alu_valid(alu_valid), .alu_class(alu_class),
  .mem_insn(mem_insn), .mem_valid(mem_valid), .mem_class(mem_class),
  .slot_err(slot_err), .align_err(align_err), .next_addr(next_addr));

// File: tb/dual_issue_decoder_tb.sv
module dual_issue_decoder_tb;
  logic clk = 0, rst_n = 0, pkt_valid = 0, stall = 0;
  logic [31:0] pkt_addr = '0;
  logic [63:0] pkt_data = '0;
  logic [31:0] alu_insn, mem_insn, next_addr;
  logic alu_valid, alu_class, mem_valid, mem_class, slot_err, align_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] e_lo = 0, e_hi = 0, e_na = 0;
  logic e_lv = 0, e_hv = 0, e_se = 0, e_ae = 0;

  always #2 clk = ~clk;

  dual_issue_decoder u_dut (.*);

  task automatic check(string req);
    n_run++;
    if (alu_insn !== e_lo || mem_insn !== e_hi || alu_valid !== e_lv || mem_valid !== e_hv ||
        alu_class !== e_lo[31] || mem_class !== e_hi[31] || slot_err !== e_se ||
        align_err !== e_ae || next_addr !== e_na) begin
      n_fail++;
      $display("FAIL %s: got lo=%h hi=%h v=%b%b c=%b%b se=%b ae=%b na=%h exp lo=%h hi=%h v=%b%b c=%b%b se=%b ae=%b na=%h",
        req, alu_insn, mem_insn, alu_valid, mem_valid, alu_class, mem_class, slot_err, align_err, next_addr,
        e_lo, e_hi, e_lv, e_hv, e_lo[31], e_hi[31], e_se, e_ae, e_na);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [31:0] a,
                      input logic [63:0] d, input string req);
    logic [31:0] lo, hi;
    logic lb, hb, mis;
    pkt_valid = v; stall = s; pkt_addr = a; pkt_data = d;
    lo = d[31:0]; hi = d[63:32];
    lb = (lo != 0) && lo[31];
    hb = (hi != 0) && !hi[31];
    mis = (a % 8) != 0;
    if (!s) begin
      e_lo = v ? lo : 0;
      e_hi = v ? hi : 0;
      e_se = v && (lb || hb);
      e_ae = v && mis;
      e_lv = v && lo != 0 && !(lb || hb || mis);
      e_hv = v && hi != 0 && !(lb || hb || mis);
      if (v && !mis) e_na = a + 8;
    end
    @(posedge clk); #1;
    check(req);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] addr;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset");
    rst_n = 1;
    addr = 32'h0000_1000;
    // R1 R2 R4 R6: sweep all opcode pairs
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        logic [31:0] lo, hi;
        lo = {i[5:0], 26'h0A5_3C1 ^ 26'(j)};
        hi = {j[5:0], 26'h153_9E7 ^ 26'(i)};
        step(1, 0, addr, {hi, lo}, "R1/R2/R4 sweep");
        addr = addr + 8;
      end
    end
    // R3 nop combinations
    step(1, 0, addr, 64'h0, "R3 both nop"); addr += 8;
    step(1, 0, addr, {32'h0, 32'h0123_4567}, "R3 high nop"); addr += 8;
    step(1, 0, addr, {32'h8C00_0004, 32'h0}, "R3 low nop"); addr += 8;
    step(1, 0, addr, {32'h0, 32'h8C00_0004}, "R4 load in low, high nop"); addr += 8;
    step(1, 0, addr, {32'h0123_4567, 32'h0}, "R4 alu in high, low nop"); addr += 8;
    // R10 dependent pair both issue
    step(1, 0, addr, {32'hAD09_0000, 32'h0129_4820}, "R10 dependent pair"); addr += 8;
    // R5 every misaligned offset
    for (int k = 1; k < 8; k++)
      step(1, 0, addr + k, {32'h8C00_0010, 32'h0000_0020}, "R5 misaligned");
    step(1, 0, addr, {32'h8C00_0010, 32'h0000_0020}, "R6 aligned after misaligned"); addr += 8;
    // R7 stall holds, inputs ignored
    for (int k = 0; k < 16; k++)
      step(1, 1, addr + k, {32'(k) * 32'h9E37_79B9, 32'(k) ^ 32'h8000_0001}, "R7 stall hold");
    step(0, 1, 32'h3, 64'h0, "R7 stall idle hold");
    // R8 idle
    step(0, 0, 32'hFFFF_FFF3, 64'hFFFF_FFFF_FFFF_FFFF, "R8 idle clear");
    step(0, 0, 32'h0, 64'h0, "R8 idle again");
    step(1, 0, addr, {32'h8C00_0000, 32'h2000_0001}, "R1 after idle"); addr += 8;
    // R9 reset mid-run
    rst_n = 0;
    e_lo = 0; e_hi = 0; e_lv = 0; e_hv = 0; e_se = 0; e_ae = 0; e_na = 0;
    @(posedge clk); #1;
    check("R9 reset mid-run");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule